// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends words on one asynchronous serial line. A word written through the write strobe lands in a holding register. When the shifter is free and transmission is enabled, the word moves straight into the shifter. A buffer-empty pulse then announces that the holding register can take the next word while the current frame is still going out. Bit timing comes from a divide-by-16 prescaler driven by an external tick at sixteen times the bit rate. Every bit edge on the line falls on a prescaler overflow.

Three static inputs shape each frame: 8 or 9 data bits, even parity placed in the top data position, and 1 or 2 stop bits. These inputs are captured when a word enters the shifter. A completion pulse marks the start of the final bit of each frame. Software can use it to prepare a line turnaround or the next word before the frame has fully ended. If a word is waiting when a frame ends, its start bit follows the last stop bit directly.

Top module: `uart_dbuf_tx`

## Requirements
- R1: `txd` is 1 while reset is asserted and whenever no frame is being shifted.
- R2: Every change of `txd` happens on the tick that completes a group of 16 baud ticks counted from reset, so each bit lasts exactly 16 ticks. A frame starts only if `run_en` is 1 and a word is held.
- R3: A frame is a 0 start bit, then the data bits least significant first (8 bits when `cfg_nine_bits`=0, 9 bits when it is 1), then the stop bits.
- R4: When `cfg_parity`=1, the top data position (bit 7 in 8-bit mode, bit 8 in 9-bit mode) carries even parity over the data bits below it, in place of the written bit.
- R5: The frame ends with one stop bit of value 1, or two when `cfg_two_stop`=1.
- R6: A word written while the shifter is idle and `run_en`=1 is taken at once. `irq_buf_empty` pulses for one cycle, two clock edges after the write edge.
- R7: `irq_tx_done` pulses for one cycle at the start of the last bit of each frame. In 1-stop mode that is the only stop bit; in 2-stop mode it is the second stop bit.
- R8: If a word is held when a frame's last bit ends, that word's start bit begins on the same overflow, and `irq_buf_empty` pulses again.
- R9: A write to a full holding register replaces the held word. The frame in progress is not affected.
- R10: Changing the configuration inputs during a frame does not alter that frame.
- R11: While `run_en`=0 no word is taken and the line stays high. The held word is sent once `run_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle tick at 16x the bit rate |
| run_en | input | 1 | Transmission enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W (9) | Word to send |
| cfg_nine_bits | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfg_parity | input | 1 | Replace the top data bit with even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| txd | output | 1 | Serial output, idles high |
| irq_buf_empty | output | 1 | Pulse: holding word moved into the shifter |
| irq_tx_done | output | 1 | Pulse: last bit of a frame has started |

## Verification
The bench decodes each frame from the line by counting baud ticks. It checks that every start edge sits on a multiple of 16 ticks. A prescaler that reloads on a write or starts a frame off-grid would fail this check. It places the completion pulse by bit slot, which exposes a design that signals after the final stop bit, or at the first of two stop bits. It queues two writes behind an active frame and checks three things: the second write wins, the next start bit follows with no idle bit, and exactly two buffer-empty pulses are seen. It also changes the configuration mid-frame and stalls `run_en`, which catches a shifter that reads its configuration live or takes words while disabled.

// File: rtl/uart_dbuf_pkg.sv
`timescale 1ns/1ps
package uart_dbuf_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SEND  = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic nine_bits;
    logic parity;
    logic two_stop;
  } tx_cfg_t;

endpackage

// File: rtl/uart_dbuf_prescaler.sv
`timescale 1ns/1ps
module uart_dbuf_prescaler #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic ovf
);
  localparam int CNT_W = $clog2(PRESCALE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
  end

  assign ovf = tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: an overflow always leaves the counter at zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == '0));

  // R2: without a tick the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/uart_dbuf_holdreg.sv
`timescale 1ns/1ps
module uart_dbuf_holdreg #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    full_d = full_q;
    if (wr_en)     full_d = 1'b1;
    else if (take) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (wr_en) data_q <= wr_data;
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R9: a write always leaves the newest word pending
  a_r9_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (full_q && data_q == $past(wr_data)));
endmodule

// File: rtl/uart_dbuf_shifter.sv
`timescale 1ns/1ps
module uart_dbuf_shifter
  import uart_dbuf_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf,
  input  logic              run_en,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  tx_cfg_t           cfg,
  output logic              take,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int REM_W   = $clog2(FRAME_W + 1);

  tx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] frame_q, frame_d, frame_new;
  logic [REM_W-1:0]   rem_q, rem_d, total_new;
  logic               txd_q, txd_d, done_q, done_d, bufe_q;
  logic [DATA_W-1:0]  field;

  // frame image built from the held word and the live configuration
  always_comb begin
    field = hold_data;
    if (!cfg.nine_bits) field[DATA_W-1] = 1'b1;
    if (cfg.parity) begin
      if (cfg.nine_bits) field[DATA_W-1] = ^hold_data[DATA_W-2:0];
      else               field[DATA_W-2] = ^hold_data[DATA_W-3:0];
    end
    frame_new = {2'b11, field, 1'b0};
    total_new = REM_W'(1)
              + (cfg.nine_bits ? REM_W'(DATA_W) : REM_W'(DATA_W - 1))
              + (cfg.two_stop ? REM_W'(2) : REM_W'(1));
  end

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    rem_d   = rem_q;
    txd_d   = txd_q;
    done_d  = 1'b0;
    take    = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (hold_full && run_en) begin
          take    = 1'b1;
          state_d = TX_ARMED;
          frame_d = frame_new;
          rem_d   = total_new - REM_W'(1);
        end
      end
      TX_ARMED: begin
        if (ovf && run_en) begin
          state_d = TX_SEND;
          txd_d   = frame_q[0];
          frame_d = {1'b1, frame_q[FRAME_W-1:1]};
        end
      end
      TX_SEND: begin
        if (ovf) begin
          if (rem_q == '0) begin
            if (hold_full && run_en) begin
              take    = 1'b1;
              txd_d   = frame_new[0];
              frame_d = {1'b1, frame_new[FRAME_W-1:1]};
              rem_d   = total_new - REM_W'(1);
            end else begin
              state_d = TX_IDLE;
              txd_d   = 1'b1;
            end
          end else begin
            txd_d   = frame_q[0];
            frame_d = {1'b1, frame_q[FRAME_W-1:1]};
            rem_d   = rem_q - REM_W'(1);
            done_d  = (rem_q == REM_W'(1));
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      frame_q <= '1;
      rem_q   <= '0;
      txd_q   <= 1'b1;
      done_q  <= 1'b0;
      bufe_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      rem_q   <= rem_d;
      txd_q   <= txd_d;
      done_q  <= done_d;
      bufe_q  <= take;
    end
  end

  assign txd       = txd_q;
  assign buf_empty = bufe_q;
  assign tx_done   = done_q;

  // R1: line is high outside an active frame
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != TX_SEND) |-> txd_q);

  // R2: the line only moves on a prescaler overflow
  a_r2_edge_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd_q) |-> $past(ovf));

  // R7: completion pulse comes from an overflow inside a frame
  a_r7_done_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(ovf) && state_q == TX_SEND && rem_q == '0));
endmodule

// File: rtl/uart_dbuf_tx.sv
`timescale 1ns/1ps
module uart_dbuf_tx
  import uart_dbuf_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_nine_bits,
  input  logic              cfg_parity,
  input  logic              cfg_two_stop,
  output logic              txd,
  output logic              irq_buf_empty,
  output logic              irq_tx_done
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              ovf, take, hold_full;
  logic [DATA_W-1:0] hold_data;
  tx_cfg_t           cfg;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign cfg = '{nine_bits: cfg_nine_bits, parity: cfg_parity, two_stop: cfg_two_stop};

  uart_dbuf_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_sync_n), .tick(baud_tick), .ovf(ovf)
  );

  uart_dbuf_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .full(hold_full), .data(hold_data)
  );

  uart_dbuf_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .ovf(ovf), .run_en(run_en),
    .hold_full(hold_full), .hold_data(hold_data), .cfg(cfg),
    .take(take), .txd(txd), .buf_empty(irq_buf_empty), .tx_done(irq_tx_done)
  );

  // R6: a buffer-empty pulse always consumes a held word
  a_r6_take_needs_word: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_buf_empty |-> ($past(hold_full) && $past(run_en)));

  // R11: nothing is taken while disabled
  a_r11_no_take_disabled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run_en && hold_full) |=> hold_full);
endmodule

// File: tb/uart_dbuf_tx_tb.sv
`timescale 1ns/1ps
module uart_dbuf_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n, baud_tick, run_en, wr_en;
  logic [8:0] wr_data;
  logic       cfg_nine_bits, cfg_parity, cfg_two_stop;
  logic       txd, irq_buf_empty, irq_tx_done;

  int n_checks = 0, n_errors = 0;
  int ticks = 0, cycles = 0, be_cnt = 0;
  logic tick_en = 1'b0, slow = 1'b0, done_flag = 1'b0;

  // nine, parity, two_stop, data[8:0]
  localparam logic [11:0] VEC [6] = '{12'h0A5, 12'h413, 12'hBC3, 12'hCFF, 12'h300, 12'hE01};

  always #2.5 clk = ~clk;

  uart_dbuf_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .run_en(run_en),
    .wr_en(wr_en), .wr_data(wr_data), .cfg_nine_bits(cfg_nine_bits),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop), .txd(txd),
    .irq_buf_empty(irq_buf_empty), .irq_tx_done(irq_tx_done)
  );

  always @(negedge clk) begin
    if (!tick_en)  baud_tick <= 1'b0;
    else if (slow) baud_tick <= ~baud_tick;
    else           baud_tick <= 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && baud_tick) ticks <= ticks + 1;
  end

  always @(negedge clk) if (irq_buf_empty) be_cnt <= be_cnt + 1;

  always @(negedge clk) begin
    if (cycles > 150000 && !done_flag) begin
      done_flag = 1'b1;
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic nine, input logic par,
                                            input logic [8:0] d);
    int n = nine ? 9 : 8;
    logic [11:0] f = '1;
    logic p = 1'b0;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) f[i+1] = d[i];
    for (int i = 0; i < n - 1; i++) p ^= d[i];
    if (par) f[n] = p;
    return f;
  endfunction

  function automatic int frame_len(input logic nine, input logic two);
    return 1 + (nine ? 9 : 8) + (two ? 2 : 1);
  endfunction

  task automatic write_word(input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // decode one frame by tick position; returns start tick and done slot offset
  task automatic recv(input int total, output logic [11:0] bits,
                      output int t0, output int done_rel);
    int guard = 0, last = -1, rel;
    bits = '1; done_rel = -1; t0 = ticks;
    while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    t0 = ticks;
    check(guard < 4000 && (t0 % 16) == 0, "R2 start on overflow", t0 % 16, 0);
    guard = 0;
    while ((ticks - t0) < 16 * total && guard < 8000) begin
      rel = ticks - t0;
      if (irq_tx_done) done_rel = rel;
      if ((rel % 16) == 8 && (rel / 16) != last) begin
        bits[rel/16] = txd;
        last = rel / 16;
      end
      @(negedge clk); guard++;
    end
  endtask

  task automatic check_frame(input string req, input logic [11:0] got,
                             input logic [11:0] exp, input int total);
    bit ok = 1'b1;
    for (int i = 0; i < total; i++) if (got[i] !== exp[i]) ok = 1'b0;
    check(ok, req, int'(got), int'(exp));
  endtask

  initial begin
    logic [11:0] bits, bits2, ex;
    int t0, t0b, dr, tot, be0, c0;
    rst_n = 1'b0; run_en = 1'b1; wr_en = 1'b0; wr_data = '0;
    cfg_nine_bits = 1'b0; cfg_parity = 1'b0; cfg_two_stop = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txd === 1'b1, "R1 txd high in reset", txd, 1);
    check(irq_buf_empty === 1'b0 && irq_tx_done === 1'b0, "R1 irqs low in reset",
          {irq_buf_empty, irq_tx_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b1;
    repeat (5) @(negedge clk);
    check(txd === 1'b1, "R1 txd high idle", txd, 1);

    // table: R3 R4 R5 R6 R7 across formats
    foreach (VEC[k]) begin
      cfg_nine_bits = VEC[k][11]; cfg_parity = VEC[k][10]; cfg_two_stop = VEC[k][9];
      tot = frame_len(VEC[k][11], VEC[k][9]);
      ex  = exp_frame(VEC[k][11], VEC[k][10], VEC[k][8:0]);
      write_word(VEC[k][8:0]);
      @(negedge clk);
      check(irq_buf_empty === 1'b1, "R6 buffer-empty after idle write", irq_buf_empty, 1);
      recv(tot, bits, t0, dr);
      check_frame("R3 R4 R5 frame bits", bits, ex, tot);
      check(dr == 16 * (tot - 1), "R7 done at last bit", dr, 16 * (tot - 1));
      check(txd === 1'b1, "R1 idle after frame", txd, 1);
    end

    // R11: disabled transmitter holds its word
    cfg_nine_bits = 1'b0; cfg_parity = 1'b0; cfg_two_stop = 1'b0;
    run_en = 1'b0; be0 = be_cnt;
    write_word(9'h05A);
    begin
      bit hi = 1'b1;
      repeat (80) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
      check(hi && be_cnt == be0, "R11 no frame while disabled", be_cnt - be0, 0);
    end
    run_en = 1'b1;
    recv(10, bits, t0, dr);
    check_frame("R11 held word sent after enable", bits, exp_frame(1'b0, 1'b0, 9'h05A), 10);

    // R8 R9: back-to-back with overwrite
    be0 = be_cnt;
    write_word(9'h031);
    repeat (2) @(negedge clk);
    write_word(9'h042);
    write_word(9'h07E);
    recv(10, bits, t0, dr);
    check_frame("R9 frame in progress intact", bits, exp_frame(1'b0, 1'b0, 9'h031), 10);
    recv(10, bits2, t0b, dr);
    check(t0b == t0 + 160, "R8 no idle gap", t0b - t0, 160);
    check_frame("R9 last write wins", bits2, exp_frame(1'b0, 1'b0, 9'h07E), 10);
    check(be_cnt - be0 == 2, "R8 second buffer-empty pulse", be_cnt - be0, 2);

    // R10: configuration captured at load
    write_word(9'h0C3);
    repeat (3) @(negedge clk);
    cfg_nine_bits = 1'b1; cfg_parity = 1'b1; cfg_two_stop = 1'b1;
    recv(10, bits, t0, dr);
    check_frame("R10 frame keeps load-time config", bits, exp_frame(1'b0, 1'b0, 9'h0C3), 10);
    check(dr == 144, "R10 done slot from load-time config", dr, 144);
    begin
      bit hi = 1'b1;
      repeat (20) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
      check(hi, "R10 no extra bits after frame", txd, 1);
    end

    // R2: bit length in ticks with a slower tick
    cfg_nine_bits = 1'b1; cfg_parity = 1'b0; cfg_two_stop = 1'b0;
    slow = 1'b1;
    write_word(9'h1A5);
    c0 = cycles;
    recv(11, bits, t0, dr);
    c0 = cycles;
    check_frame("R2 slow tick frame", bits, exp_frame(1'b1, 1'b0, 9'h1A5), 11);
    t0b = cycles;
    check(ticks - t0 == 176, "R2 16 ticks per bit", ticks - t0, 176);
    slow = 1'b0;

    repeat (10) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule